// File: doc/BRIEF.md
# Two-Phase Toggle Handshake Latch Pipeline

This block is a linear FIFO built from a chain of identical stages. Each stage holds one data word in a level-enabled register and has a one-gate controller. The stages pass words to each other with two-phase toggle handshakes. A sender announces a new word by inverting its request wire. A receiver confirms it by inverting its acknowledge wire. Both edge directions count as events, and no wire ever returns to zero.

A stage's register is open (transparent) while the stage waits for a word. It closes as soon as it has taken one, and it opens again when the downstream stage confirms that it has taken the word over. The enable of each stage is the XNOR of the stage's own done toggle and the done toggle of the stage after it. That one done toggle serves as the request to the next stage and as the acknowledge to the previous stage.

An optional per-stage transform stands in for the logic between stages. A request delay of a set number of cycles stands in for the matching delay, so that the request reaches the next stage only after its data has settled. The delay is zero for a plain FIFO.

Top module: `tsig_pipe`

## Requirements
- R1: After reset, `up_ack` and `dn_req` are 0, every stage register is open, and the pipeline holds no word.
- R2: Every word accepted at the input toggles `up_ack` exactly once. A rising toggle and a falling toggle are both single events.
- R3: An open stage whose incoming request differs from its done toggle captures the word on the next clock edge. On an empty pipeline, `up_ack` toggles one cycle after `up_req` toggles.
- R4: The enable of each stage is XNOR(own done, next stage's done, or `dn_ack` for the last stage). A closed stage holds its word unchanged. With `dn_ack` held, the pipeline accepts exactly DEPTH words and leaves the next one unacknowledged.
- R5: A stage's done toggle is both the acknowledge to the stage before it and the request to the stage after it. On an empty pipeline, a word travels from an `up_req` toggle to a `dn_req` toggle in DEPTH*(1+REQ_DLY) cycles.
- R6: The request to the next stage is delayed by REQ_DLY cycles after the data register changes. `dn_data` is valid whenever `dn_req` differs from `dn_ack`.
- R7: No word is overwritten before it is passed on. Words leave in order, with none lost and none duplicated, under any stall pattern on `dn_ack`.
- R8: With transform XF_INC, each stage adds 1 modulo 2^W to the word it passes on, so `dn_data` equals `up_data` + DEPTH. With XF_PASS, the word passes unchanged.
- R9: `dn_req` toggles exactly once per word delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Active-low reset |
| up_data | input | W | Word offered by the producer |
| up_req | input | 1 | Producer request toggle |
| up_ack | output | 1 | Acknowledge toggle to the producer |
| dn_data | output | W | Word offered to the consumer |
| dn_req | output | 1 | Request toggle to the consumer |
| dn_ack | input | 1 | Consumer acknowledge toggle |

## Verification
The bench measures, one word at a time on an empty pipeline, how long a word takes to reach the output and how long the input acknowledge takes. This separates the per-stage delay from the capture cycle. A fill pattern with the consumer held tells a correct one-word-per-stage capacity apart from overrun or from a stage that closes too early. Random streams follow, with stall rates on `dn_ack` from none to near-constant and with bursty producer gaps. These show whether words stay ordered, complete and unique when the stages keep opening and closing at different times. Counting the toggles on both sides confirms one event per word.

// File: rtl/tsig_pkg.sv
package tsig_pkg;
    typedef enum logic [0:0] {
        XF_PASS = 1'b0,
        XF_INC  = 1'b1
    } xform_e;
endpackage

// File: rtl/tsig_req_delay.sv
module tsig_req_delay #(
    parameter int DLY = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_i,
    output logic tog_o
);
    generate
        if (DLY == 0) begin : g_direct
            assign tog_o = tog_i;
        end else begin : g_shift
            logic [DLY-1:0] sh_d, sh_q;

            always_comb begin
                sh_d = DLY'({sh_q, tog_i});
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= sh_d;
            end

            assign tog_o = sh_q[DLY-1];
        end
    endgenerate
endmodule

// File: rtl/tsig_stage.sv
module tsig_stage
    import tsig_pkg::*;
#(
    parameter int     W  = 8,
    parameter xform_e XF = XF_PASS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_i,
    input  logic [W-1:0] d_i,
    input  logic         ack_i,
    output logic         done_o,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] data;
        logic         done;
    } st_t;

    st_t st_d, st_q;
    logic en;

    always_comb begin
        st_d = st_q;
        en   = ~(st_q.done ^ ack_i);
        if (en && (req_i != st_q.done)) begin
            st_d.data = d_i;
            st_d.done = req_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;

    generate
        if (XF == XF_INC) begin : g_inc
            assign q_o = st_q.data + W'(1);
        end else begin : g_pass
            assign q_o = st_q.data;
        end
    endgenerate

    AST_CAPTURE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.done) |-> ($past(st_q.done) == $past(ack_i))); // R4

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.done) |-> ($past(req_i) != $past(st_q.done))); // R2

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done != ack_i) |=> $stable(st_q.data)); // R7
endmodule

// File: rtl/tsig_pipe.sv
module tsig_pipe
    import tsig_pkg::*;
#(
    parameter int     W       = 8,
    parameter int     DEPTH   = 4,
    parameter int     REQ_DLY = 0,
    parameter xform_e XF      = XF_PASS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] up_data,
    input  logic         up_req,
    output logic         up_ack,
    output logic [W-1:0] dn_data,
    output logic         dn_req,
    input  logic         dn_ack
);
    localparam int NLINK = DEPTH + 1;

    logic [DEPTH-1:0] done;
    logic [NLINK-1:0] req;
    logic [W-1:0]     dat [NLINK];
    logic [DEPTH-1:0] ack_nx;

    assign req[0] = up_req;
    assign dat[0] = up_data;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == DEPTH - 1) begin : g_last
                assign ack_nx[i] = dn_ack;
            end else begin : g_mid
                assign ack_nx[i] = done[i+1];
            end

            tsig_stage #(.W(W), .XF(XF)) u_stage (
                .clk    (clk),
                .rst_n  (rst_n),
                .req_i  (req[i]),
                .d_i    (dat[i]),
                .ack_i  (ack_nx[i]),
                .done_o (done[i]),
                .q_o    (dat[i+1])
            );

            tsig_req_delay #(.DLY(REQ_DLY)) u_dly (
                .clk   (clk),
                .rst_n (rst_n),
                .tog_i (done[i]),
                .tog_o (req[i+1])
            );
        end
    endgenerate

    assign up_ack  = done[0];
    assign dn_req  = req[DEPTH];
    assign dn_data = dat[DEPTH];

    AST_RESET_IDLE: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (!up_ack && !dn_req)); // R1
endmodule

// File: tb/tsig_pipe_tb.sv
module tsig_pipe_tb;
    import tsig_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int W     = 16;
    localparam int DEPTH = 4;
    localparam int DLY   = 2;
    localparam int MAXN  = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] up_data = '0;
    logic up_req = 1'b0;
    logic up_ack;
    logic [W-1:0] dn_data;
    logic dn_req;
    logic dn_ack = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] sent [MAXN];
    int wr = 0;
    int rd = 0;
    bit cons_on = 1'b0;
    int stall_pct = 0;
    int up_tog = 0;
    int dn_tog = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsig_pipe #(.W(W), .DEPTH(DEPTH), .REQ_DLY(DLY), .XF(XF_INC)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .up_data(up_data), .up_req(up_req), .up_ack(up_ack),
        .dn_data(dn_data), .dn_req(dn_req), .dn_ack(dn_ack)
    );

    function automatic logic [W-1:0] expect_out(logic [W-1:0] v);
        return v + W'(DEPTH);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // toggle monitors (R2, R9)
    logic up_ack_p = 1'b0, dn_req_p = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (up_ack != up_ack_p) up_tog++;
            if (dn_req != dn_req_p) dn_tog++;
        end
        up_ack_p <= up_ack;
        dn_req_p <= dn_req;
    end

    // consumer with random stalls
    always @(negedge clk) begin
        if (rst_n && cons_on && (dn_req != dn_ack)) begin
            if (($urandom % 100) >= stall_pct) begin
                check(dn_data == expect_out(sent[rd]), "R7/R8 data order", int'(dn_data),
                      int'(expect_out(sent[rd])));
                rd++;
                dn_ack = ~dn_ack;
            end
        end
    end

    task automatic push(logic [W-1:0] v);
        int t = 0;
        while (up_req != up_ack && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(t < 5000, "R7 producer acceptance", t, 0);
        up_data = v;
        sent[wr] = v;
        wr++;
        up_req = ~up_req;
    endtask

    initial begin
        void'($urandom(32'd7));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(up_ack == 1'b0, "R1 up_ack reset", int'(up_ack), 0);
        check(dn_req == 1'b0, "R1 dn_req reset", int'(dn_req), 0);

        // latency on empty pipe (R3, R5, R1 transparency)
        begin
            int n = 0;
            int ack_at = -1;
            up_data = 16'h1234;
            sent[wr] = 16'h1234;
            wr++;
            up_req = 1'b1;
            while (dn_req == 1'b0 && n < 200) begin
                @(negedge clk);
                n++;
                if (ack_at < 0 && up_ack) ack_at = n;
            end
            check(ack_at == 1, "R3 ack one cycle after req", ack_at, 1);
            check(n == DEPTH * (1 + DLY), "R5 end-to-end latency", n, DEPTH * (1 + DLY));
            check(dn_data == 16'h1238, "R8 transform adds DEPTH", int'(dn_data), 16'h1238);
            check(dn_req != dn_ack, "R6 request pending with valid data", int'(dn_req), 1);
        end

        // fill with consumer stalled (R4)
        for (int k = 0; k < DEPTH - 1; k++) push(W'($urandom));
        repeat (3 * DEPTH * (1 + DLY)) @(negedge clk);
        check(up_ack == up_req, "R4 DEPTH words accepted", int'(up_ack), int'(up_req));
        push(W'($urandom));
        repeat (50) @(negedge clk);
        check(up_ack != up_req, "R4 extra word not acknowledged", int'(up_ack), int'(~up_req));
        check(dn_data == expect_out(sent[0]), "R4 closed stage holds word", int'(dn_data),
              int'(expect_out(sent[0])));

        // random streams with varying stall rates (R7)
        cons_on = 1'b1;
        for (int seg = 0; seg < 4; seg++) begin
            stall_pct = (seg == 0) ? 0 : (seg == 1) ? 30 : (seg == 2) ? 70 : 95;
            for (int k = 0; k < 100; k++) begin
                int gap = (seg[0]) ? int'($urandom % 4) : 0;
                repeat (gap) @(negedge clk);
                push(W'($urandom));
            end
        end
        begin
            int t = 0;
            while (rd != wr && t < 20000) begin
                @(negedge clk);
                t++;
            end
        end
        repeat (10) @(negedge clk);
        check(rd == wr, "R7 all words delivered", rd, wr);
        check(dn_tog == wr, "R9 dn_req toggles per word", dn_tog, wr);
        check(up_tog == wr, "R2 up_ack toggles per word", up_tog, wr);
        check(up_ack == up_req && dn_req == dn_ack, "R7 pipeline drained", int'(dn_req), int'(dn_ack));

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", rd, wr);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule